// File: doc/BRIEF.md
# Power-On Strap Latch with Clock Mode Decoder

This block sits beside the clock synthesis core of a board clock generator. Two frequency-select straps and one USB/IO strap share their pins with clock outputs. Each strap is read once, shortly after power-on reset is released. After that capture the pads may switch to driving clocks. The capture moment is marked by a one-cycle strobe, which pad control logic uses to change pin direction.

A configuration bit chooses the effective 3-bit select code. It is either the register-supplied code, or the live test pin placed above the two latched frequency straps. The code is decoded into one of three forms:
- a nominal frequency set for running modes;
- a high-impedance flag;
- a test mode in which every output is a fixed division of an external test clock.

Test mode can also be entered without any code. Three rising edges on the active-low PCI stop input, while the crystal input is held low, latch test mode until the next reset.

Top module: `fsel_strap_ctrl`

## Requirements
- R1: While reset is asserted, `strap_valid` and `strap_sample` are 0, `test_mode` is 0, and the latched straps hold their pull-up defaults: `strap_fs` = 2'b11 and `strap_usbsel` = 1.
- R2: The straps are captured on the 16th rising clock edge after reset is released. `strap_sample` is 1 only in the cycle just before that edge, and `strap_valid` is 1 from that edge onward.
- R3: Once `strap_valid` is 1, changes on the strap pins do not alter `strap_fs` or `strap_usbsel`.
- R4: With `cfg_override` = 1, `sel_code` equals `cfg_code`. With `cfg_override` = 0, `sel_code` is {`test_pin`, `strap_fs`[1], `strap_fs`[0]}.
- R5: In running modes, `sel_code` 001/010/100/101/110/111 gives CPU MHz 50/66/90/133/120/100, PCI (tenths of MHz) 250/330/300/333/300/333, and AGP (tenths) 500/660/600/666/600/666. All divider outputs are 0 in these modes.
- R6: `sel_code` 000 with no sequence-entered test mode sets `out_hiz` = 1. All frequency and divider outputs are then 0.
- R7: In test mode, the dividers are CPU 2, PCI 6, AGP 3 and REF 1, and the USB/IO divider is 4 when `strap_usbsel` = 0 and 8 when it is 1. All frequency outputs are 0 and `out_hiz` is 0. `sel_code` 011 selects test mode.
- R8: In running modes, `usbio_mhz` is 48 when `strap_usbsel` = 0 and 24 when it is 1.
- R9: Three rising edges of `pci_stop_n`, seen while `xtal_in` is low, set `test_mode` = 1 whatever `sel_code` is. It stays set until reset, even after `xtal_in` returns high.
- R10: Seeing `xtal_in` high before test mode is latched clears the edge count. Fewer than three edges since the last clear leave `test_mode` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| fs_strap_pin | input | 2 | Frequency-select strap levels from shared pins |
| usbsel_strap_pin | input | 1 | USB/IO rate strap level from shared pin |
| test_pin | input | 1 | Live test pin, upper bit of the pin-based code |
| xtal_in | input | 1 | Crystal input level, for sequence qualification |
| pci_stop_n | input | 1 | Active-low PCI stop input, edge source for test entry |
| cfg_override | input | 1 | 1 selects the register code, 0 selects pins |
| cfg_code | input | 3 | Register-supplied select code |
| strap_sample | output | 1 | One-cycle strobe before strap capture |
| strap_valid | output | 1 | Straps have been captured |
| strap_fs | output | 2 | Latched frequency straps |
| strap_usbsel | output | 1 | Latched USB/IO strap |
| sel_code | output | 3 | Effective select code |
| out_hiz | output | 1 | All clock outputs high impedance |
| test_mode | output | 1 | Outputs derive from the test clock |
| cpu_mhz | output | 8 | Nominal CPU clock, MHz |
| pci_d10 | output | 10 | Nominal PCI clock, tenths of MHz |
| agp_d10 | output | 10 | Nominal AGP clock, tenths of MHz |
| usbio_mhz | output | 8 | Nominal USB/IO clock, MHz |
| div_cpu | output | 4 | CPU test-clock divider |
| div_pci | output | 4 | PCI test-clock divider |
| div_agp | output | 4 | AGP test-clock divider |
| div_ref | output | 4 | REF test-clock divider |
| div_usb | output | 4 | USB/IO test-clock divider |

## Verification
All eight register codes are applied through the override path, which separates the six running frequency sets, the high-impedance code and the test code. Pin-based selection is tried with two different strap patterns and with the test pin toggled. This shows that the latched levels, not the live ones, reach the code, and that the USB/IO strap moves both the running rate and the test divider. The entry sequence is driven as two edges, then a crystal-high interval, then two more edges and a third. This tells apart a counter that clears from one that only accumulates, and confirms that the latched state survives the crystal returning high.

// File: rtl/fsel_pkg.sv
package fsel_pkg;
    localparam int CODE_W  = 3;
    localparam int FS_W    = 2;
    localparam int MHZ_W   = 8;
    localparam int TENTH_W = 10;
    localparam int DIV_W   = 4;

    typedef enum logic [1:0] {MODE_RUN, MODE_HIZ, MODE_TEST} mode_e;

    typedef struct packed {
        logic [MHZ_W-1:0]   cpu;
        logic [TENTH_W-1:0] pci;
        logic [TENTH_W-1:0] agp;
        logic [MHZ_W-1:0]   usbio;
    } freq_t;

    typedef struct packed {
        logic [DIV_W-1:0] cpu;
        logic [DIV_W-1:0] pci;
        logic [DIV_W-1:0] agp;
        logic [DIV_W-1:0] refc;
        logic [DIV_W-1:0] usb;
    } div_t;

    localparam logic [CODE_W-1:0] CODE_HIZ  = 3'b000;
    localparam logic [CODE_W-1:0] CODE_TEST = 3'b011;

    // Nominal running frequencies; zero for non-running codes
    function automatic freq_t run_freq(input logic [CODE_W-1:0] code, input logic usb_half);
        freq_t f;
        f = '0;
        case (code)
            3'b001: begin f.cpu = 8'd50;  f.pci = 10'd250; f.agp = 10'd500; end
            3'b010: begin f.cpu = 8'd66;  f.pci = 10'd330; f.agp = 10'd660; end
            3'b100: begin f.cpu = 8'd90;  f.pci = 10'd300; f.agp = 10'd600; end
            3'b101: begin f.cpu = 8'd133; f.pci = 10'd333; f.agp = 10'd666; end
            3'b110: begin f.cpu = 8'd120; f.pci = 10'd300; f.agp = 10'd600; end
            3'b111: begin f.cpu = 8'd100; f.pci = 10'd333; f.agp = 10'd666; end
            default: f = '0;
        endcase
        if (f.cpu != '0) f.usbio = usb_half ? 8'd24 : 8'd48;
        return f;
    endfunction

    function automatic div_t test_div(input logic usb_half);
        div_t d;
        d.cpu  = 4'd2;
        d.pci  = 4'd6;
        d.agp  = 4'd3;
        d.refc = 4'd1;
        d.usb  = usb_half ? 4'd8 : 4'd4;
        return d;
    endfunction
endpackage

// File: rtl/fsel_strap_capture.sv
module fsel_strap_capture
    import fsel_pkg::*;
#(
    parameter int SETTLE = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [FS_W-1:0] fs_pin,
    input  logic            usb_pin,
    output logic            sample,
    output logic            valid,
    output logic [FS_W-1:0] fs_q,
    output logic            usb_q
);
    localparam int CNT_W = $clog2(SETTLE + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE - 1);

    logic [CNT_W-1:0] cnt;

    assign sample = !rst && !valid && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            valid <= 1'b0;
            fs_q  <= '1;
            usb_q <= 1'b1;
        end else if (!valid) begin
            if (cnt == LAST) begin
                valid <= 1'b1;
                fs_q  <= fs_pin;
                usb_q <= usb_pin;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assert_strobe_then_valid_R2: assert property (@(posedge clk) disable iff (rst)
        sample |=> valid);
    assert_strap_hold_R3: assert property (@(posedge clk) disable iff (rst)
        valid |=> (valid && $stable(fs_q) && $stable(usb_q)));
endmodule

// File: rtl/fsel_test_entry.sv
module fsel_test_entry #(
    parameter int SYNC_STAGES = 2,
    parameter int EDGES       = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic xtal_in,
    input  logic stop_n,
    output logic entered
);
    localparam int CNT_W = $clog2(EDGES + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(EDGES);

    logic [SYNC_STAGES-1:0] xs_sh, ps_sh;
    logic                   ps_d;
    logic [CNT_W-1:0]       cnt;
    logic                   xs, ps, rise;

    assign xs      = xs_sh[SYNC_STAGES-1];
    assign ps      = ps_sh[SYNC_STAGES-1];
    assign rise    = ps && !ps_d;
    assign entered = (cnt == FULL);

    always_ff @(posedge clk) begin
        if (rst) begin
            xs_sh <= '1;
            ps_sh <= '1;
            ps_d  <= 1'b1;
            cnt   <= '0;
        end else begin
            xs_sh <= {xs_sh[SYNC_STAGES-2:0], xtal_in};
            ps_sh <= {ps_sh[SYNC_STAGES-2:0], stop_n};
            ps_d  <= ps;
            if (!entered) begin
                if (xs)        cnt <= '0;
                else if (rise) cnt <= cnt + 1'b1;
            end
        end
    end

    assert_entry_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        entered |=> entered);
    assert_xtal_clears_R10: assert property (@(posedge clk) disable iff (rst)
        (xs && !entered) |=> (cnt == '0));
endmodule

// File: rtl/fsel_mode_decode.sv
module fsel_mode_decode
    import fsel_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic              seq_test,
    input  logic              usb_half,
    output mode_e             mode,
    output freq_t             freq,
    output div_t              div
);
    always_comb begin
        if (seq_test || code == CODE_TEST) begin
            mode = MODE_TEST;
            freq = '0;
            div  = test_div(usb_half);
        end else if (code == CODE_HIZ) begin
            mode = MODE_HIZ;
            freq = '0;
            div  = '0;
        end else begin
            mode = MODE_RUN;
            freq = run_freq(code, usb_half);
            div  = '0;
        end
    end
endmodule

// File: rtl/fsel_strap_ctrl.sv
module fsel_strap_ctrl
    import fsel_pkg::*;
#(
    parameter int SETTLE      = 16,
    parameter int SYNC_STAGES = 2,
    parameter int EDGES       = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         fs_strap_pin,
    input  logic               usbsel_strap_pin,
    input  logic               test_pin,
    input  logic               xtal_in,
    input  logic               pci_stop_n,
    input  logic               cfg_override,
    input  logic [2:0]         cfg_code,
    output logic               strap_sample,
    output logic               strap_valid,
    output logic [1:0]         strap_fs,
    output logic               strap_usbsel,
    output logic [2:0]         sel_code,
    output logic               out_hiz,
    output logic               test_mode,
    output logic [7:0]         cpu_mhz,
    output logic [9:0]         pci_d10,
    output logic [9:0]         agp_d10,
    output logic [7:0]         usbio_mhz,
    output logic [3:0]         div_cpu,
    output logic [3:0]         div_pci,
    output logic [3:0]         div_agp,
    output logic [3:0]         div_ref,
    output logic [3:0]         div_usb
);
    logic  seq_test;
    mode_e mode;
    freq_t freq;
    div_t  div;

    fsel_strap_capture #(.SETTLE(SETTLE)) u_cap (
        .clk(clk), .rst(rst),
        .fs_pin(fs_strap_pin), .usb_pin(usbsel_strap_pin),
        .sample(strap_sample), .valid(strap_valid),
        .fs_q(strap_fs), .usb_q(strap_usbsel)
    );

    fsel_test_entry #(.SYNC_STAGES(SYNC_STAGES), .EDGES(EDGES)) u_seq (
        .clk(clk), .rst(rst),
        .xtal_in(xtal_in), .stop_n(pci_stop_n),
        .entered(seq_test)
    );

    assign sel_code = cfg_override ? cfg_code : {test_pin, strap_fs};

    fsel_mode_decode u_dec (
        .code(sel_code), .seq_test(seq_test), .usb_half(strap_usbsel),
        .mode(mode), .freq(freq), .div(div)
    );

    assign out_hiz   = (mode == MODE_HIZ);
    assign test_mode = (mode == MODE_TEST);
    assign cpu_mhz   = freq.cpu;
    assign pci_d10   = freq.pci;
    assign agp_d10   = freq.agp;
    assign usbio_mhz = freq.usbio;
    assign div_cpu   = div.cpu;
    assign div_pci   = div.pci;
    assign div_agp   = div.agp;
    assign div_ref   = div.refc;
    assign div_usb   = div.usb;

    assert_hiz_not_test_R6: assert property (@(posedge clk) disable iff (rst)
        !(out_hiz && test_mode));
    assert_seq_forces_test_R9: assert property (@(posedge clk) disable iff (rst)
        seq_test |-> (test_mode && cpu_mhz == '0));
endmodule

// File: tb/test_fsel_strap_ctrl.sv
module test_fsel_strap_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] fs_strap_pin = 2'b10;
    logic usbsel_strap_pin = 1'b0;
    logic test_pin = 1'b1;
    logic xtal_in = 1'b1;
    logic pci_stop_n = 1'b1;
    logic cfg_override = 1'b0;
    logic [2:0] cfg_code = 3'b111;
    logic strap_sample, strap_valid, strap_usbsel, out_hiz, test_mode;
    logic [1:0] strap_fs;
    logic [2:0] sel_code;
    logic [7:0] cpu_mhz, usbio_mhz;
    logic [9:0] pci_d10, agp_d10;
    logic [3:0] div_cpu, div_pci, div_agp, div_ref, div_usb;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk; // 10-unit period: 100 MHz with 1 ns units

    fsel_strap_ctrl i_fsel_strap_ctrl (.*);

    // code, cpu, pci, agp, hiz, test, div cpu/pci/agp
    localparam logic [44:0] TBL [8] = '{
        {3'd0, 8'd0,   10'd0,   10'd0,   1'b1, 1'b0, 4'd0, 4'd0, 4'd0},
        {3'd1, 8'd50,  10'd250, 10'd500, 1'b0, 1'b0, 4'd0, 4'd0, 4'd0},
        {3'd2, 8'd66,  10'd330, 10'd660, 1'b0, 1'b0, 4'd0, 4'd0, 4'd0},
        {3'd3, 8'd0,   10'd0,   10'd0,   1'b0, 1'b1, 4'd2, 4'd6, 4'd3},
        {3'd4, 8'd90,  10'd300, 10'd600, 1'b0, 1'b0, 4'd0, 4'd0, 4'd0},
        {3'd5, 8'd133, 10'd333, 10'd666, 1'b0, 1'b0, 4'd0, 4'd0, 4'd0},
        {3'd6, 8'd120, 10'd300, 10'd600, 1'b0, 1'b0, 4'd0, 4'd0, 4'd0},
        {3'd7, 8'd100, 10'd333, 10'd666, 1'b0, 1'b0, 4'd0, 4'd0, 4'd0}
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] fs, input logic usb);
        fs_strap_pin = fs;
        usbsel_strap_pin = usb;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (20) @(negedge clk);
    endtask

    task automatic stop_pulse();
        pci_stop_n = 1'b0;
        repeat (3) @(negedge clk);
        pci_stop_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 strap_valid", strap_valid, 0);
        check("R1 strap_sample", strap_sample, 0);
        check("R1 strap_fs", strap_fs, 3);
        check("R1 strap_usbsel", strap_usbsel, 1);
        check("R1 test_mode", test_mode, 0);

        // R2 capture timing
        rst = 1'b0;
        repeat (15) @(posedge clk);
        @(negedge clk);
        check("R2 strobe before capture", strap_sample, 1);
        check("R2 not yet valid", strap_valid, 0);
        @(negedge clk);
        check("R2 valid after 16th edge", strap_valid, 1);
        check("R2 strobe gone", strap_sample, 0);
        check("R2 strap_fs captured", strap_fs, 2);
        check("R2 strap_usb captured", strap_usbsel, 0);

        // R3 later pin changes ignored
        fs_strap_pin = 2'b01;
        usbsel_strap_pin = 1'b1;
        repeat (5) @(negedge clk);
        check("R3 strap_fs held", strap_fs, 2);
        check("R3 strap_usb held", strap_usbsel, 0);

        // R4 pin-based code, R8 usb rate
        check("R4 pin code", sel_code, 6);
        check("R5 pin code cpu", cpu_mhz, 120);
        check("R8 usbio 48", usbio_mhz, 48);
        test_pin = 1'b0;
        @(negedge clk);
        check("R4 test pin bit", sel_code, 2);
        check("R5 code 010 cpu", cpu_mhz, 66);
        test_pin = 1'b1;

        // R4/R5/R6/R7 table walk through override
        cfg_override = 1'b1;
        for (int i = 0; i < 8; i++) begin
            cfg_code = TBL[i][44:42];
            @(negedge clk);
            check("R4 override code", sel_code, TBL[i][44:42]);
            check("R5 cpu", cpu_mhz, TBL[i][41:34]);
            check("R5 pci", pci_d10, TBL[i][33:24]);
            check("R5 agp", agp_d10, TBL[i][23:14]);
            check("R6 hiz", out_hiz, TBL[i][13]);
            check("R7 test", test_mode, TBL[i][12]);
            check("R7 div cpu", div_cpu, TBL[i][11:8]);
            check("R7 div pci", div_pci, TBL[i][7:4]);
            check("R7 div agp", div_agp, TBL[i][3:0]);
        end
        cfg_code = 3'b011;
        @(negedge clk);
        check("R7 div ref", div_ref, 1);
        check("R7 div usb strap0", div_usb, 4);
        cfg_code = 3'b000;
        @(negedge clk);
        check("R6 usbio zero", usbio_mhz, 0);
        check("R6 div usb zero", div_usb, 0);

        // Second strap pattern
        cfg_override = 1'b0;
        do_reset(2'b01, 1'b1);
        check("R4 pin code 2", sel_code, 5);
        check("R5 cpu 133", cpu_mhz, 133);
        check("R8 usbio 24", usbio_mhz, 24);
        cfg_override = 1'b1;
        cfg_code = 3'b011;
        @(negedge clk);
        check("R7 div usb strap1", div_usb, 8);

        // R9/R10 entry sequence
        cfg_code = 3'b111;
        xtal_in = 1'b0;
        repeat (4) @(negedge clk);
        stop_pulse();
        stop_pulse();
        check("R10 two edges", test_mode, 0);
        xtal_in = 1'b1;
        repeat (5) @(negedge clk);
        xtal_in = 1'b0;
        repeat (4) @(negedge clk);
        stop_pulse();
        stop_pulse();
        check("R10 count cleared", test_mode, 0);
        stop_pulse();
        check("R9 entered", test_mode, 1);
        check("R9 div cpu", div_cpu, 2);
        check("R9 cpu zero", cpu_mhz, 0);
        xtal_in = 1'b1;
        repeat (6) @(negedge clk);
        check("R9 sticky", test_mode, 1);
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset clears test", test_mode, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule